// File: doc/BRIEF.md
# Reloadable Prescaled Interval Timer

This block is an 8-bit interval timer meant to sit among the registers of a small processor. Software reads and writes the running count like any other register. The count moves up on a schedule taken from an instruction-cycle tick. A 4-bit rate code picks how many ticks pass between steps. When the count passes 0xFF, it takes its next value from a reload register rather than wrapping to zero, and it raises a sticky interrupt flag.

The rate is built on a base period of two ticks. Codes 0 to 7 stretch that base by 2, 4, and so on up to 256. Code 8 and every code above it use the base period unstretched. All writes go through one port, with a 2-bit selector that picks the target register. The reload value and the rate code can be written but not read back. The interrupt request is the flag masked by an enable bit, and it is held as a level until software clears the flag.

Top module: `rld_timer`

## Requirements
- R1: After reset the count reads 0x00, the reload value is 0x00, the rate code is 0, the flag reads 0, the enable is 0 and the request is low.
- R2: A write with wr_sel = 2'b00 puts wr_data on cnt_rd on the clock edge that takes the write.
- R3: With rate code c in 0..7 (written with wr_sel = 2'b10, code in wr_data[3:0]), the count steps by one every 2^(c+2) ticks; code 0 therefore steps every 4 ticks.
- R4: With rate code 8 the count steps every 2 ticks, and codes 9 to 15 behave exactly like code 8.
- R5: Only clock cycles with cyc_tick high advance the timer; cycles without a tick leave both the count and the prescaler unchanged.
- R6: A step taken while the count is 0xFF loads the reload value (written with wr_sel = 2'b01) instead of 0x00.
- R7: Every rollover sets the flag. A control write (wr_sel = 2'b11) copies wr_data[0] into the flag, so writing 0 clears it. A rollover in the same cycle as a control write wins.
- R8: irq_req is high exactly when the flag is 1 and the enable bit (wr_data[1] of the last control write) is 1. It stays high as a level for as long as both are set.
- R9: A count write in the same cycle as a step wins, causes no rollover or flag set, and restarts the prescaler, so the next step comes one full period after the write.
- R10: Writing the reload value or the rate code leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_tick | input | 1 | One pulse per instruction cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 count, 01 reload, 10 rate code, 11 control |
| wr_data | input | 8 | Write data |
| cnt_rd | output | 8 | Current count |
| irq_flag | output | 1 | Sticky rollover flag |
| irq_req | output | 1 | Flag masked by the enable bit |

## Verification
The properties assume that wr_sel is always one of its four encodings whenever wr_en is high. They also assume that ticks and writes may come in any cycle, including the same one. The properties check step size, hold, reload, flag stickiness and write priority cycle by cycle. They do not check the step period, because that period depends on the prescaler phase. The stimulus always follows a rate-code change with a count write, which restarts the prescaler, so every period the bench measures starts from a known phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 8;
  localparam int PSC_W  = 4;
  localparam int NPOW   = 8;
  localparam int DIV_W  = NPOW + 1;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'b00,
    SEL_RELOAD = 2'b01,
    SEL_RATE   = 2'b10,
    SEL_CTRL   = 2'b11
  } tmr_sel_e;

  localparam int CTRL_FLAG_BIT = 0;
  localparam int CTRL_EN_BIT   = 1;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 4,
  parameter int NPOW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rate_wr,
  input  logic [PSC_W-1:0] rate_data,
  input  logic             restart,
  output logic             step
);
  localparam int DIV_W = NPOW + 1;

  logic [PSC_W-1:0] rate_q, rate_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] span_mask;
  int unsigned      span_bits;

  // number of low divider bits that must all be one for a step
  always_comb begin
    if (int'(rate_q) < NPOW) span_bits = int'(rate_q) + 2;
    else                     span_bits = 1;
  end

  for (genvar gi = 0; gi < DIV_W; gi++) begin : g_mask
    assign span_mask[gi] = (gi < span_bits);
  end

  assign step = tick && ((div_q | ~span_mask) == {DIV_W{1'b1}});

  always_comb begin
    rate_d = rate_q;
    if (rate_wr) rate_d = rate_data;
  end

  always_comb begin
    div_d = div_q;
    if (restart)   div_d = '0;
    else if (tick) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= '0;
    else if (rate_wr) rate_q <= rate_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (restart || tick) div_q <= div_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             cnt_wr,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output logic             rollover
);
  logic [CNT_W-1:0] cnt_d, rld_d;
  logic             cnt_ce;

  assign rollover = step && !cnt_wr && (cnt_q == {CNT_W{1'b1}});
  assign cnt_ce   = cnt_wr || step;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr)        cnt_d = wr_data;
    else if (rollover) cnt_d = rld_q;
    else if (step)     cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    rld_d = rld_q;
    if (rld_wr) rld_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rld_q <= '0;
    else if (rld_wr) rld_q <= rld_d;
  end
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic rollover,
  input  logic ctrl_wr,
  input  logic ctrl_flag,
  input  logic ctrl_en,
  output logic flag_q,
  output logic en_q,
  output logic irq
);
  logic flag_d, en_d;

  always_comb begin
    flag_d = flag_q;
    if (rollover)     flag_d = 1'b1;
    else if (ctrl_wr) flag_d = ctrl_flag;
  end

  always_comb begin
    en_d = en_q;
    if (ctrl_wr) en_d = ctrl_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (rollover || ctrl_wr) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (ctrl_wr) en_q <= en_d;
  end

  assign irq = flag_q & en_q;
endmodule

// File: rtl/rld_timer.sv
module rld_timer
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_rd,
  output logic             irq_flag,
  output logic             irq_req
);
  logic             rst_sync_n;
  logic             cnt_wr, rld_wr, rate_wr, ctrl_wr;
  logic             step_w, roll_w, en_w;
  logic [CNT_W-1:0] rld_w;

  assign cnt_wr  = wr_en && (wr_sel == SEL_COUNT);
  assign rld_wr  = wr_en && (wr_sel == SEL_RELOAD);
  assign rate_wr = wr_en && (wr_sel == SEL_RATE);
  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tmr_prescaler #(.PSC_W(PSC_W), .NPOW(NPOW)) u_psc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (cyc_tick),
    .rate_wr   (rate_wr),
    .rate_data (wr_data[PSC_W-1:0]),
    .restart   (cnt_wr),
    .step      (step_w)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step     (step_w),
    .cnt_wr   (cnt_wr),
    .rld_wr   (rld_wr),
    .wr_data  (wr_data),
    .cnt_q    (cnt_rd),
    .rld_q    (rld_w),
    .rollover (roll_w)
  );

  tmr_irq_flag u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rollover  (roll_w),
    .ctrl_wr   (ctrl_wr),
    .ctrl_flag (wr_data[CTRL_FLAG_BIT]),
    .ctrl_en   (wr_data[CTRL_EN_BIT]),
    .flag_q    (irq_flag),
    .en_q      (en_w),
    .irq       (irq_req)
  );
endmodule

// File: rtl/rld_timer_chk.sv
module rld_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_tick,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] cnt_rd,
  input logic       irq_flag,
  input logic       irq_req,
  input logic       step,
  input logic [7:0] reload
);
  logic cw, kw;
  assign cw = wr_en && (wr_sel == 2'b00);
  assign kw = wr_en && (wr_sel == 2'b11);

  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> (cnt_rd == $past(wr_data))); // R2

  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> cyc_tick); // R5

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cw && cnt_rd != 8'hFF) |=> (cnt_rd == $past(cnt_rd) + 8'd1)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_tick && !cw) |=> $stable(cnt_rd)); // R5

  AST_ROLL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cw && cnt_rd == 8'hFF) |=> (cnt_rd == $past(reload))); // R6

  AST_ROLL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cw && cnt_rd == 8'hFF) |=> irq_flag); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !kw) |=> irq_flag); // R7

  AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_flag); // R8

  AST_WRITE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && !irq_flag) |=> !irq_flag); // R9
endmodule

bind rld_timer rld_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cyc_tick (cyc_tick),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .cnt_rd   (cnt_rd),
  .irq_flag (irq_flag),
  .irq_req  (irq_req),
  .step     (step_w),
  .reload   (rld_w)
);

// File: tb/rld_timer_tb_top.sv
`timescale 1ns/1ps
module rld_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_tick;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [7:0] cnt_rd;
  logic       irq_flag;
  logic       irq_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rld_timer dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_tick (cyc_tick),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .cnt_rd   (cnt_rd),
    .irq_flag (irq_flag),
    .irq_req  (irq_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_tick = 1'b1;
    end
    @(negedge clk);
    cyc_tick = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 count", cnt_rd, 8'h00);
    check("R1 flag", irq_flag, 0);
    check("R1 req", irq_req, 0);
    ticks(3);
    check("R1 code0 no step at 3", cnt_rd, 8'h00);
    ticks(1);
    check("R1 code0 step at 4", cnt_rd, 8'h01);
  endtask

  task automatic t_code0;
    wr(2'b00, 8'h10);
    check("R2 write", cnt_rd, 8'h10);
    ticks(3);
    check("R3 code0 3 ticks", cnt_rd, 8'h10);
    ticks(9);
    check("R3 code0 12 ticks", cnt_rd, 8'h13);
  endtask

  task automatic t_code3;
    wr(2'b10, 8'h03);
    wr(2'b00, 8'h40);
    ticks(31);
    check("R3 code3 31 ticks", cnt_rd, 8'h40);
    ticks(1);
    check("R3 code3 32 ticks", cnt_rd, 8'h41);
  endtask

  task automatic t_code7;
    wr(2'b10, 8'h07);
    wr(2'b00, 8'h00);
    ticks(511);
    check("R3 code7 511 ticks", cnt_rd, 8'h00);
    ticks(1);
    check("R3 code7 512 ticks", cnt_rd, 8'h01);
  endtask

  task automatic t_code8;
    wr(2'b10, 8'h08);
    wr(2'b00, 8'h05);
    ticks(1);
    check("R4 code8 1 tick", cnt_rd, 8'h05);
    ticks(5);
    check("R4 code8 6 ticks", cnt_rd, 8'h08);
    wr(2'b10, 8'h0C);
    wr(2'b00, 8'h05);
    ticks(6);
    check("R4 code12 6 ticks", cnt_rd, 8'h08);
    wr(2'b10, 8'h0F);
    wr(2'b00, 8'h05);
    ticks(4);
    check("R4 code15 4 ticks", cnt_rd, 8'h07);
  endtask

  task automatic t_gaps;
    wr(2'b10, 8'h08);
    wr(2'b00, 8'h20);
    for (int i = 0; i < 4; i++) begin
      ticks(1);
      repeat (3) @(negedge clk);
    end
    check("R5 sparse ticks", cnt_rd, 8'h22);
    repeat (20) @(negedge clk);
    check("R5 no tick hold", cnt_rd, 8'h22);
  endtask

  task automatic t_rollover;
    wr(2'b11, 8'h00);
    wr(2'b01, 8'hA0);
    wr(2'b10, 8'h08);
    wr(2'b00, 8'hFE);
    ticks(2);
    check("R6 at FF", cnt_rd, 8'hFF);
    check("R7 no flag before roll", irq_flag, 0);
    ticks(2);
    check("R6 reload", cnt_rd, 8'hA0);
    check("R7 flag set", irq_flag, 1);
    check("R8 masked", irq_req, 0);
    wr(2'b11, 8'h03);
    check("R8 enabled", irq_req, 1);
    ticks(6);
    check("R8 level held", irq_req, 1);
    check("R7 flag sticky", irq_flag, 1);
    wr(2'b11, 8'h02);
    check("R7 cleared", irq_flag, 0);
    check("R8 dropped", irq_req, 0);
  endtask

  task automatic t_priority;
    wr(2'b10, 8'h08);
    wr(2'b00, 8'hFF);
    ticks(1);
    @(negedge clk);
    cyc_tick = 1'b1; wr_en = 1'b1; wr_sel = 2'b00; wr_data = 8'h55;
    @(negedge clk);
    cyc_tick = 1'b0; wr_en = 1'b0;
    check("R9 write wins", cnt_rd, 8'h55);
    check("R9 no flag", irq_flag, 0);
    ticks(1);
    check("R9 restart 1 tick", cnt_rd, 8'h55);
    ticks(1);
    check("R9 restart 2 ticks", cnt_rd, 8'h56);
  endtask

  task automatic t_side;
    wr(2'b00, 8'h42);
    wr(2'b01, 8'h11);
    check("R10 reload write", cnt_rd, 8'h42);
    wr(2'b10, 8'h05);
    check("R10 rate write", cnt_rd, 8'h42);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cyc_tick = 1'b0; wr_en = 1'b0; wr_sel = 2'b00; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_code0();
    t_code3();
    t_code7();
    t_code8();
    t_gaps();
    t_rollover();
    t_priority();
    t_side();
    done = 1;
    finish_run();
  end
endmodule